// File: doc/BRIEF.md
# Synchronous Multi-Ratio Clock Divider Tree

This block turns one fast master clock, running at twice the chosen processor-clock rate, into every phase-related system clock group: the processor clock, a half-rate copy of it, a mid-rate group, a peripheral-bus group and an interrupt-controller clock. All of them are decoded from one shared phase counter, so each rising edge of every output falls on a rising edge of the master clock. The slower groups' rising edges meet the processor clock's rising edges whenever the ratio allows it.

A three-bit select word picks the operating mode. It can choose a low-rate mode (the 100-MHz processor class), a high-rate mode (the 133-MHz class), a fixed binary-ratio test mode or an output-disable mode. Two codes are reserved and keep the current mode. In the low-rate mode the mid-rate group divides the master clock by three. That path uses both master clock edges so that its duty cycle stays balanced. An active-low power-down input parks every output low.

A new mode or a park/resume request takes effect only at the end of a full common period, when all outputs are low. Every output therefore leaves or re-enters operation with complete pulses, and on resume all groups rise together.

Top module: `syncdiv_tree`

## Requirements
- R1: While reset is asserted and after its release until the first mode load, every clock output is low and `drv_en` is low.
- R2: The select word {rate_hi, mode_sel[1], mode_sel[0]} decodes as: 000 output-disable (`drv_en` low, all outputs low), 010/011 low-rate, 110/111 high-rate, 100 test. `mode_sel[0]` has no effect on the waveforms.
- R3: Codes 001 and 101 are reserved. Applying them leaves the active mode and the waveforms unchanged.
- R4: In low-rate mode, measured in master periods with the high phase first, the ratios are: processor clock /2, half-rate /4, peripheral /6, interrupt /12. Each is high for exactly half its period.
- R5: In high-rate mode the ratios are: processor /2, half-rate /4, mid-rate /4, peripheral /8, interrupt /16. Each is high for half its period.
- R6: In low-rate mode the mid-rate group divides by 3. It rises on a master rising edge and stays high for 1.5 master periods, falling on a master falling edge.
- R7: In test mode the ratios are: processor /2, half-rate /4, mid-rate /2, peripheral /4, interrupt /8.
- R8: The mode and run state are sampled only on the last master cycle of the common period (12 cycles in low-rate mode, 16 otherwise), or on any cycle while parked. The period counter never exceeds its last phase.
- R9: With `pwr_dn_n` low at a period end, all outputs are driven low from the next cycle on, and no pulse is cut short. A low level that does not span a period end has no effect. `drv_en` is unchanged by power-down.
- R10: When parked with `pwr_dn_n` high and a non-disable mode selected, all outputs rise together one master cycle later.
- R11: Every rising edge of the half-rate and interrupt outputs coincides with a processor-clock rising edge. Every peripheral rising edge coincides with a mid-rate rising edge.
- R12: All copies inside a group carry identical waveforms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock at twice the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_hi | input | 1 | Select word bit 2 (high-rate class) |
| mode_sel | input | 2 | Select word bits 1:0 |
| pwr_dn_n | input | 1 | Active-low power-down request |
| drv_en | output | 1 | Output driver enable, low in output-disable mode |
| cpu_clk | output | N_CPU | Processor clock copies |
| cpu_half | output | 1 | Processor clock divided by two |
| mid_clk | output | N_MID | Mid-rate group copies |
| pci_clk | output | N_PCI | Peripheral-bus group copies |
| apic_clk | output | 1 | Interrupt-controller clock |

## Verification
The hardest cases to reach are a select or power-down change that arrives partway through a common period, and a power-down pulse too short to span a period end. In both, the block must hold its present waveforms until the period closes. The stimulus changes its inputs a few cycles after a period boundary, and also pulses `pwr_dn_n` low for one cycle mid-period. A behavioural model, which counts elapsed master cycles and half-cycles, is compared in both halves of every master cycle. This catches the odd-divide falling edge, which comes on a master falling edge.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;

  typedef enum logic [1:0] {
    MD_OFF = 2'd0,
    MD_LO  = 2'd1,
    MD_HI  = 2'd2,
    MD_TST = 2'd3
  } tree_mode_e;

  // common period lengths in master cycles (lcm of each mode's divisors)
  localparam int PERIOD_LO = 12;
  localparam int PERIOD_HI = 16;
  localparam int PH_W      = $clog2(PERIOD_HI);

  // per-group divisors, master periods
  localparam int DIV_CPU      = 2;
  localparam int DIV_HALF     = 4;
  localparam int DIV_MID_LO   = 3;
  localparam int DIV_MID_HI   = 4;
  localparam int DIV_MID_TST  = 2;
  localparam int DIV_PCI_LO   = 6;
  localparam int DIV_PCI_HI   = 8;
  localparam int DIV_PCI_TST  = 4;
  localparam int DIV_APIC_LO  = 12;
  localparam int DIV_APIC_HI  = 16;
  localparam int DIV_APIC_TST = 8;

  function automatic logic [PH_W-1:0] last_phase(tree_mode_e m);
    return (m == MD_LO) ? PH_W'(PERIOD_LO - 1) : PH_W'(PERIOD_HI - 1);
  endfunction

  // high during the first half of each divided period
  function automatic logic in_high_half(logic [PH_W-1:0] c, int d);
    return ((int'(c) % d) * 2) < d;
  endfunction

  function automatic int pick_div(tree_mode_e m, int d_lo, int d_hi, int d_tst);
    case (m)
      MD_LO:   return d_lo;
      MD_HI:   return d_hi;
      default: return d_tst;
    endcase
  endfunction

  // select word decode; reserved codes keep the present mode
  function automatic tree_mode_e sel_decode(logic [2:0] s, tree_mode_e keep);
    case (s)
      3'b000:         return MD_OFF;
      3'b010, 3'b011: return MD_LO;
      3'b110, 3'b111: return MD_HI;
      3'b100:         return MD_TST;
      default:        return keep;
    endcase
  endfunction

endpackage

// File: rtl/tree_phase_seq.sv
module tree_phase_seq
  import syncdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      sel,
  input  logic            pwr_dn_n,
  output logic [PH_W-1:0] cnt,
  output tree_mode_e      mode,
  output logic            run
);

  logic [PH_W-1:0] last_w;
  logic            period_end;
  tree_mode_e      next_mode;

  always_comb begin
    last_w     = last_phase(mode);
    period_end = !run || (cnt == last_w);
    next_mode  = sel_decode(sel, mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MD_OFF;
      run  <= 1'b0;
      cnt  <= '0;
    end else if (period_end) begin
      mode <= next_mode;
      run  <= pwr_dn_n && (next_mode != MD_OFF);
      cnt  <= '0;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_phase(mode));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != last_phase(mode)) |=> ($stable(mode) && $stable(run)));

endmodule

// File: rtl/tree_even_tap.sv
module tree_even_tap
  import syncdiv_pkg::*;
#(
  parameter int D_LO  = 4,
  parameter int D_HI  = 4,
  parameter int D_TST = 4
) (
  input  logic [PH_W-1:0] cnt,
  input  tree_mode_e      mode,
  input  logic            run,
  output logic            tap
);

  localparam int D_MAX = (D_LO > D_HI) ? ((D_LO > D_TST) ? D_LO : D_TST)
                                       : ((D_HI > D_TST) ? D_HI : D_TST);

  int div_w;

  always_comb begin
    div_w = pick_div(mode, D_LO, D_HI, D_TST);
    tap   = run && in_high_half(cnt, div_w) && (D_MAX <= PERIOD_HI);
  end

endmodule

// File: rtl/tree_mid_tap.sv
module tree_mid_tap
  import syncdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] cnt,
  input  tree_mode_e      mode,
  input  logic            run,
  output logic            tap
);

  logic lo_mode;
  logic p_pos;   // rising-edge phase
  logic n_q;     // half-cycle delayed copy (odd divide only)

  always_comb begin
    lo_mode = (mode == MD_LO);
    if (lo_mode)
      p_pos = run && ((int'(cnt) % DIV_MID_LO) == 0);
    else
      p_pos = run && in_high_half(cnt, pick_div(mode, DIV_MID_LO, DIV_MID_HI, DIV_MID_TST));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= 1'b0;
    else        n_q <= p_pos && lo_mode;
  end

  assign tap = p_pos | n_q;

  // R6
  odd_stretch_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(p_pos) && !p_pos && lo_mode) |-> tap);

endmodule

// File: rtl/syncdiv_tree.sv
module syncdiv_tree
  import syncdiv_pkg::*;
#(
  parameter int N_CPU = 3,
  parameter int N_MID = 3,
  parameter int N_PCI = 10
) (
  input  logic             clk_mst,
  input  logic             rst_n,
  input  logic             rate_hi,
  input  logic [1:0]       mode_sel,
  input  logic             pwr_dn_n,
  output logic             drv_en,
  output logic [N_CPU-1:0] cpu_clk,
  output logic             cpu_half,
  output logic [N_MID-1:0] mid_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             apic_clk
);

  logic [PH_W-1:0] cnt;
  tree_mode_e      mode;
  logic            run;
  logic            cpu_raw, half_raw, mid_raw, pci_raw, apic_raw;

  tree_phase_seq u_seq (
    .clk      (clk_mst),
    .rst_n    (rst_n),
    .sel      ({rate_hi, mode_sel}),
    .pwr_dn_n (pwr_dn_n),
    .cnt      (cnt),
    .mode     (mode),
    .run      (run)
  );

  tree_even_tap #(.D_LO(DIV_CPU), .D_HI(DIV_CPU), .D_TST(DIV_CPU)) u_cpu (
    .cnt(cnt), .mode(mode), .run(run), .tap(cpu_raw));

  tree_even_tap #(.D_LO(DIV_HALF), .D_HI(DIV_HALF), .D_TST(DIV_HALF)) u_half (
    .cnt(cnt), .mode(mode), .run(run), .tap(half_raw));

  tree_even_tap #(.D_LO(DIV_PCI_LO), .D_HI(DIV_PCI_HI), .D_TST(DIV_PCI_TST)) u_pci (
    .cnt(cnt), .mode(mode), .run(run), .tap(pci_raw));

  tree_even_tap #(.D_LO(DIV_APIC_LO), .D_HI(DIV_APIC_HI), .D_TST(DIV_APIC_TST)) u_apic (
    .cnt(cnt), .mode(mode), .run(run), .tap(apic_raw));

  tree_mid_tap u_mid (
    .clk   (clk_mst),
    .rst_n (rst_n),
    .cnt   (cnt),
    .mode  (mode),
    .run   (run),
    .tap   (mid_raw)
  );

  // fan-out to the copies of each group
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign cpu_clk[i] = cpu_raw;
  end
  for (genvar i = 0; i < N_MID; i++) begin : g_mid
    assign mid_clk[i] = mid_raw;
  end
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    assign pci_clk[i] = pci_raw;
  end

  assign cpu_half = half_raw;
  assign apic_clk = apic_raw;
  assign drv_en   = (mode != MD_OFF);

  // R11
  apic_on_cpu_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
    $rose(apic_raw) |-> $rose(cpu_raw));

  // R11
  half_on_cpu_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
    $rose(half_raw) |-> $rose(cpu_raw));

  // R11
  pci_on_mid_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
    $rose(pci_raw) |-> $rose(mid_raw));

  // R9
  parked_low_chk: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !run |-> !(cpu_raw || half_raw || mid_raw || pci_raw || apic_raw));

endmodule

// File: tb/test_syncdiv_tree.sv
`timescale 1ns/1ps
module test_syncdiv_tree;

  localparam int NC = 3;
  localparam int NM = 3;
  localparam int NP = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rate_hi = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          pwr_dn_n = 1'b1;
  logic          drv_en;
  logic [NC-1:0] cpu_clk;
  logic          cpu_half;
  logic [NM-1:0] mid_clk;
  logic [NP-1:0] pci_clk;
  logic          apic_clk;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;   // 100 MHz

  syncdiv_tree #(.N_CPU(NC), .N_MID(NM), .N_PCI(NP)) i_syncdiv_tree (
    .clk_mst(clk), .rst_n(rst_n), .rate_hi(rate_hi), .mode_sel(mode_sel),
    .pwr_dn_n(pwr_dn_n), .drv_en(drv_en), .cpu_clk(cpu_clk), .cpu_half(cpu_half),
    .mid_clk(mid_clk), .pci_clk(pci_clk), .apic_clk(apic_clk));

  // ---- behavioural reference: 0 off, 1 low-rate, 2 high-rate, 3 test ----
  int m_mode = 0;
  bit m_run  = 0;
  int m_ph   = 0;

  always @(posedge clk) begin
    int period;
    int nm;
    period = (m_mode == 1) ? 12 : 16;
    if (!rst_n) begin
      m_mode <= 0; m_run <= 0; m_ph <= 0;
    end else if (!m_run || m_ph == period - 1) begin
      case ({rate_hi, mode_sel})
        3'd0:       nm = 0;
        3'd2, 3'd3: nm = 1;
        3'd4:       nm = 3;
        3'd6, 3'd7: nm = 2;
        default:    nm = m_mode;
      endcase
      m_mode <= nm;
      m_run  <= pwr_dn_n && (nm != 0);
      m_ph   <= 0;
    end else begin
      m_ph <= m_ph + 1;
    end
  end

  function automatic bit first_half_of(int ph, int d);
    return ((ph % d) < (d + 1) / 2) && ((ph % d) * 2 < d);
  endfunction

  function automatic int div_of(int md, int lo, int hi, int ts);
    return (md == 1) ? lo : ((md == 2) ? hi : ts);
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_tag, what, act, exp, $time);
    end
  endtask

  bit p_cpu = 0, p_apic = 0, p_half = 0;

  task automatic compare(int hf);
    bit e_cpu, e_half, e_mid, e_pci, e_apic;
    e_cpu  = m_run && first_half_of(m_ph, 2);
    e_half = m_run && first_half_of(m_ph, 4);
    if (m_mode == 1) e_mid = m_run && ((2 * (m_ph % 3) + hf) < 3);  // R6: 3 half-periods high
    else             e_mid = m_run && first_half_of(m_ph, div_of(m_mode, 3, 4, 2));
    e_pci  = m_run && first_half_of(m_ph, div_of(m_mode, 6, 8, 4));
    e_apic = m_run && first_half_of(m_ph, div_of(m_mode, 12, 16, 8));
    chk(drv_en == (m_mode != 0), "drv_en", drv_en, (m_mode != 0));
    chk(cpu_clk == {NC{e_cpu}}, "cpu_clk R12", cpu_clk, {NC{e_cpu}});
    chk(cpu_half == e_half, "cpu_half", cpu_half, e_half);
    chk(mid_clk == {NM{e_mid}}, "mid_clk R12", mid_clk, {NM{e_mid}});
    chk(pci_clk == {NP{e_pci}}, "pci_clk R12", pci_clk, {NP{e_pci}});
    chk(apic_clk == e_apic, "apic_clk", apic_clk, e_apic);
    if (hf == 0) begin
      // R11: slow rising edges only together with a processor rising edge
      if (apic_clk && !p_apic)
        chk(cpu_clk[0] && !p_cpu, "R11 apic edge vs cpu edge", cpu_clk[0], 1);
      if (cpu_half && !p_half)
        chk(cpu_clk[0] && !p_cpu, "R11 half edge vs cpu edge", cpu_clk[0], 1);
      p_cpu = cpu_clk[0]; p_apic = apic_clk; p_half = cpu_half;
    end
  endtask

  always @(posedge clk) begin
    #2 compare(0);
    #5 compare(1);
  end

  task automatic drive(logic [2:0] s, logic pd_n, string tag);
    @(posedge clk); #3;
    {rate_hi, mode_sel} = s;
    pwr_dn_n = pd_n;
    cur_tag = tag;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    rate_hi = 1'b0; mode_sel = 2'b10; pwr_dn_n = 1'b1;
    wait_cyc(3); #3;
    // R1: reset state at the ports
    chk(!drv_en && cpu_clk == '0 && !cpu_half && mid_clk == '0 && pci_clk == '0 && !apic_clk,
        "R1 reset outputs", {drv_en, cpu_half, apic_clk}, 0);
    rst_n = 1'b1;
    cur_tag = "R4/R6";
    wait_cyc(40);
    drive(3'b011, 1'b1, "R2");        // sel bit 0 ignored
    wait_cyc(30);
    drive(3'b001, 1'b1, "R3");        // reserved, keep low-rate
    wait_cyc(30);
    wait_cyc(5);
    drive(3'b110, 1'b1, "R8/R5");     // mid-period switch to high-rate
    wait_cyc(50);
    drive(3'b101, 1'b1, "R3");
    wait_cyc(40);
    drive(3'b100, 1'b1, "R7");
    wait_cyc(40);
    drive(3'b000, 1'b1, "R2");        // output disable
    wait_cyc(30);
    drive(3'b111, 1'b1, "R5");
    wait_cyc(37);
    drive(3'b111, 1'b0, "R9");        // power-down mid-period
    wait_cyc(40);
    drive(3'b111, 1'b1, "R10");
    wait_cyc(30);
    drive(3'b010, 1'b1, "R4");
    wait_cyc(27);
    drive(3'b010, 1'b0, "R9");        // one-cycle pulse, no period end inside
    drive(3'b010, 1'b1, "R9");
    wait_cyc(30);
    drive(3'b010, 1'b0, "R9");
    wait_cyc(30);
    drive(3'b100, 1'b1, "R10");
    wait_cyc(40);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule